// File: doc/BRIEF.md
# I2C Configuration Slave with Atomic Register Commit

This block is a serial-bus slave that gives a bus master write and read access to a bank of configuration bytes. The default bank holds twelve bytes, which is 96 bits. The block oversamples SCL and SDA on the system clock, recognises START and STOP, and answers one 7-bit address. Four bits of that address are fixed. The three low bits come from two strap inputs, and each strap input has three levels. The slave acknowledges bytes by pulling SDA low through an open-drain enable. It sends read data MSB first.

A write carries three parts in order: the address, one command byte that the block discards, and the data bytes. Incoming data bytes go into a shadow buffer. The live configuration outputs change in a single cycle, and only when the STOP arrives after a write in which every data byte was received. A STOP that comes earlier leaves the live bank untouched, and so does a repeated START. A read returns a fixed identification byte first, then a reserved byte, then the live configuration bytes.

Top module: `i2c_cfg_slave`

## Requirements
- R1: A falling SDA while SCL is high is a START and restarts address reception. A rising SDA while SCL is high is a STOP; it ends the transaction and releases SDA. A STOP is also detected straight after a START.
- R2: The slave address is 1101 followed by three low bits chosen by `sel_hi` and `sel_lo`. Each select input encodes LOW as 00, MID as 01 and HIGH as 10 or 11. The pair index is 3*hi+lo, which gives 000 for LOW/LOW up to 111 for HIGH/MID. HIGH/HIGH maps to 110.
- R3: When the address matches, the slave pulls SDA low for the ninth clock of the address byte. In a write it also does so for every byte it receives. It gives no acknowledge to any other address and ignores the rest of that transaction.
- R4: In a write, the byte after the address (read/write bit 0) is a command byte and is discarded. Data byte k goes to `cfg_q[8k+7:8k]`, with k counting from 0.
- R5: `cfg_q` changes only on a STOP that follows a write with all twelve data bytes received, and all twelve bytes change together. A STOP after fewer bytes leaves `cfg_q` unchanged. A repeated START also leaves `cfg_q` unchanged and clears the byte count.
- R6: Write bytes beyond the twelfth are acknowledged and discarded.
- R7: A read (read/write bit 1) returns 0x05, then 0x00, then configuration bytes 0 to 11 in order, each MSB first. Bytes after those fourteen read as 0xFF.
- R8: When the master does not acknowledge a read byte, the slave releases SDA and stays silent until the next STOP or START. After that it serves new transactions normally.
- R9: After reset `cfg_q` is all zero and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| sel_hi | input | 2 | Upper address strap (00 LOW, 01 MID, 1x HIGH) |
| sel_lo | input | 2 | Lower address strap (00 LOW, 01 MID, 1x HIGH) |
| cfg_q | output | 96 | Live configuration bank, byte k at bits 8k+7:8k |

## Verification
The bench targets four corner cases:
- Writes of seven and twelve bytes that end in a STOP or a repeated START. A design that committed early or committed partially would show changed `cfg_q` bits in these cases.
- A fourteen-byte write. A design without a saturating counter would wrap and overwrite byte 0, or would withhold the acknowledge.
- Every strap combination, including HIGH/HIGH and the 11 code, along with a neighbouring address that must go unanswered. A mapping error in any of these would show up here.
- Reads past the fourteenth byte, and a read the master stops with a NACK. These expose a slave that keeps driving SDA, or one that fails to serve the next transaction.

// File: rtl/cfgi2c_pkg.sv
package cfgi2c_pkg;

    localparam logic [3:0] ADDR_FIXED = 4'b1101;
    localparam logic [7:0] RSV_CODE   = 8'h00;
    localparam logic [7:0] PAST_END   = 8'hFF;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WDATA,
        ST_ACK_W,
        ST_ACK_R,
        ST_RDATA,
        ST_MACK,
        ST_WAIT
    } xfer_state_e;

    typedef struct packed {
        logic scl_s;
        logic sda_s;
        logic scl_rise;
        logic scl_fall;
        logic start_evt;
        logic stop_evt;
    } bus_evt_t;

    // Three-level strap: 00 low, 01 mid, 10/11 high
    function automatic logic [1:0] strap_level(input logic [1:0] code);
        return (code[1]) ? 2'd2 : code;
    endfunction

    function automatic logic [2:0] addr_low_bits(input logic [1:0] hi, input logic [1:0] lo);
        logic [3:0] idx;
        idx = 4'd3 * {2'b00, strap_level(hi)} + {2'b00, strap_level(lo)};
        return (idx == 4'd8) ? 3'd6 : idx[2:0];
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import cfgi2c_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);
    logic [1:0] scl_ff, sda_ff;
    logic       scl_d, sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_ff <= 2'b11;
            sda_ff <= 2'b11;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[0], scl_i};
            sda_ff <= {sda_ff[0], sda_i};
            scl_d  <= scl_ff[1];
            sda_d  <= sda_ff[1];
        end
    end

    always_comb begin
        evt.scl_s     = scl_ff[1];
        evt.sda_s     = sda_ff[1];
        evt.scl_rise  = scl_ff[1] & ~scl_d;
        evt.scl_fall  = ~scl_ff[1] & scl_d;
        evt.start_evt = scl_ff[1] & scl_d & sda_d & ~sda_ff[1];
        evt.stop_evt  = scl_ff[1] & scl_d & ~sda_d & sda_ff[1];
    end
endmodule

// File: rtl/i2c_addr_sel.sv
module i2c_addr_sel
    import cfgi2c_pkg::*;
(
    input  logic [1:0] sel_hi,
    input  logic [1:0] sel_lo,
    output logic [6:0] dev_addr
);
    always_comb dev_addr = {ADDR_FIXED, addr_low_bits(sel_hi, sel_lo)};
endmodule

// File: rtl/cfg_byte_bank.sv
module cfg_byte_bank #(
    parameter int NBYTES = 12
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         stage_en,
    input  logic [$clog2(NBYTES)-1:0]    stage_idx,
    input  logic [7:0]                   stage_data,
    input  logic                         commit,
    input  logic [$clog2(NBYTES)-1:0]    rd_idx,
    output logic [7:0]                   rd_data,
    output logic [8*NBYTES-1:0]          live_q
);
    localparam int IW = $clog2(NBYTES);

    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        logic [7:0] shadow_r;
        logic [7:0] live_r;

        always_ff @(posedge clk) begin
            if (rst) begin
                shadow_r <= '0;
            end else if (stage_en && stage_idx == IW'(g)) begin
                shadow_r <= stage_data;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                live_r <= '0;
            end else if (commit) begin
                live_r <= shadow_r;
            end
        end

        assign live_q[8*g +: 8] = live_r;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NBYTES; i++) begin
            if (rd_idx == IW'(i)) rd_data = live_q[8*i +: 8];
        end
    end
endmodule

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave
    import cfgi2c_pkg::*;
#(
    parameter int         NBYTES  = 12,
    parameter logic [7:0] ID_CODE = 8'h05
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    input  logic [1:0]            sel_hi,
    input  logic [1:0]            sel_lo,
    output logic [8*NBYTES-1:0]   cfg_q
);
    localparam int             IW      = $clog2(NBYTES);
    localparam int             CW      = $clog2(NBYTES + 3);
    localparam logic [CW-1:0]  K_FULL  = CW'(NBYTES);
    localparam logic [CW-1:0]  K_RDEND = CW'(NBYTES + 2);

    bus_evt_t    evt;
    logic [6:0]  dev_addr;
    xfer_state_e state;
    logic [3:0]  bit_cnt;
    logic [7:0]  rx_sh, tx_sh, rd_sel, bank_rd;
    logic [CW-1:0] wr_cnt, rd_cnt;
    logic        cmd_seen, nack;
    logic        ev_start, ev_stop, byte_end;
    logic        stage_en, commit;
    logic        scl_s;

    i2c_line_sync u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .evt(evt)
    );

    i2c_addr_sel u_addr (
        .sel_hi(sel_hi), .sel_lo(sel_lo), .dev_addr(dev_addr)
    );

    assign ev_start = evt.start_evt;
    assign ev_stop  = evt.stop_evt;
    assign scl_s    = evt.scl_s;
    assign byte_end = evt.scl_fall && (bit_cnt == 4'd8);
    assign stage_en = !ev_start && !ev_stop && (state == ST_WDATA) && byte_end
                      && cmd_seen && (wr_cnt != K_FULL);
    assign commit   = ev_stop && (wr_cnt == K_FULL);

    cfg_byte_bank #(.NBYTES(NBYTES)) u_bank (
        .clk(clk), .rst(rst),
        .stage_en(stage_en), .stage_idx(IW'(wr_cnt)), .stage_data(rx_sh),
        .commit(commit),
        .rd_idx(IW'(rd_cnt - CW'(2))), .rd_data(bank_rd),
        .live_q(cfg_q)
    );

    always_comb begin
        if (rd_cnt == CW'(0))        rd_sel = ID_CODE;
        else if (rd_cnt == CW'(1))   rd_sel = RSV_CODE;
        else if (rd_cnt < K_RDEND)   rd_sel = bank_rd;
        else                         rd_sel = PAST_END;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            sda_oe   <= 1'b0;
            bit_cnt  <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            wr_cnt   <= '0;
            rd_cnt   <= '0;
            cmd_seen <= 1'b0;
            nack     <= 1'b0;
        end else if (ev_start) begin
            state    <= ST_ADDR;
            sda_oe   <= 1'b0;
            bit_cnt  <= '0;
            wr_cnt   <= '0;
            rd_cnt   <= '0;
            cmd_seen <= 1'b0;
        end else if (ev_stop) begin
            state    <= ST_IDLE;
            sda_oe   <= 1'b0;
        end else begin
            case (state)
                ST_ADDR, ST_WDATA: begin
                    if (evt.scl_rise) begin
                        rx_sh   <= {rx_sh[6:0], evt.sda_s};
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (byte_end) begin
                        bit_cnt <= '0;
                        if (state == ST_ADDR) begin
                            if (rx_sh[7:1] == dev_addr) begin
                                sda_oe <= 1'b1;
                                state  <= rx_sh[0] ? ST_ACK_R : ST_ACK_W;
                            end else begin
                                state  <= ST_WAIT;
                            end
                        end else begin
                            sda_oe   <= 1'b1;
                            state    <= ST_ACK_W;
                            cmd_seen <= 1'b1;
                            if (stage_en) wr_cnt <= wr_cnt + CW'(1);
                        end
                    end
                end
                ST_ACK_W: begin
                    if (evt.scl_fall) begin
                        sda_oe <= 1'b0;
                        state  <= ST_WDATA;
                    end
                end
                ST_ACK_R: begin
                    if (evt.scl_fall) begin
                        tx_sh   <= rd_sel;
                        sda_oe  <= ~rd_sel[7];
                        bit_cnt <= '0;
                        state   <= ST_RDATA;
                    end
                end
                ST_RDATA: begin
                    if (evt.scl_rise) begin
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (byte_end) begin
                        sda_oe <= 1'b0;
                        state  <= ST_MACK;
                        if (rd_cnt != K_RDEND) rd_cnt <= rd_cnt + CW'(1);
                    end else if (evt.scl_fall) begin
                        tx_sh  <= {tx_sh[6:0], 1'b0};
                        sda_oe <= ~tx_sh[6];
                    end
                end
                ST_MACK: begin
                    if (evt.scl_rise) begin
                        nack <= evt.sda_s;
                    end else if (evt.scl_fall) begin
                        if (nack) begin
                            state <= ST_WAIT;
                        end else begin
                            tx_sh   <= rd_sel;
                            sda_oe  <= ~rd_sel[7];
                            bit_cnt <= '0;
                            state   <= ST_RDATA;
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/i2c_cfg_slave_chk.sv
module i2c_cfg_slave_chk #(
    parameter int NBYTES = 12
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        sda_oe,
    input logic                        scl_s,
    input logic                        start_evt,
    input logic                        stop_evt,
    input logic [8*NBYTES-1:0]         cfg_q,
    input logic [$clog2(NBYTES+3)-1:0] wr_cnt
);
    localparam int CW = $clog2(NBYTES + 3);
    localparam logic [CW-1:0] FULL = CW'(NBYTES);

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (rst)
        stop_evt |=> !sda_oe) else $error("stop did not release SDA"); // R1

    AST_START_RELEASES: assert property (@(posedge clk) disable iff (rst)
        start_evt |=> !sda_oe) else $error("start did not release SDA"); // R1

    AST_PULL_ON_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_s) else $error("SDA pulled while SCL high"); // R3

    AST_CFG_ONLY_ON_STOP: assert property (@(posedge clk) disable iff (rst)
        (cfg_q != $past(cfg_q)) |-> $past(stop_evt)) else $error("cfg changed without STOP"); // R5

    AST_CFG_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        (cfg_q != $past(cfg_q)) |-> ($past(wr_cnt) == FULL)) else $error("partial commit"); // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        wr_cnt <= FULL) else $error("write count overflow"); // R6
endmodule

bind i2c_cfg_slave i2c_cfg_slave_chk #(.NBYTES(NBYTES)) u_chk (
    .clk(clk), .rst(rst), .sda_oe(sda_oe), .scl_s(scl_s),
    .start_evt(ev_start), .stop_evt(ev_stop), .cfg_q(cfg_q), .wr_cnt(wr_cnt)
);

// File: tb/tb_i2c_cfg_slave.sv
module tb_i2c_cfg_slave;
    localparam int NB = 12;
    localparam int Q  = 8;

    logic clk = 1'b0, rst = 1'b1;
    logic m_scl = 1'b1, m_low = 1'b0;
    logic [1:0] s_hi = 2'b00, s_lo = 2'b01;
    logic sda_line, oe;
    logic [8*NB-1:0] cfg, exp_cfg;
    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    assign sda_line = ~(m_low | oe);
    always #10 clk = ~clk;

    i2c_cfg_slave dut (
        .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(oe),
        .sel_hi(s_hi), .sel_lo(s_lo), .cfg_q(cfg)
    );

    task automatic chk(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, expv);
        end
    endtask

    task automatic wcyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b0; wcyc(Q);
        m_scl = 1'b1; wcyc(Q);
        m_low = 1'b1; wcyc(Q);
        m_scl = 1'b0;
    endtask

    task automatic bus_stop();
        wcyc(Q); m_low = 1'b1; wcyc(Q);
        m_scl = 1'b1; wcyc(Q);
        m_low = 1'b0; wcyc(2*Q);
    endtask

    task automatic bit_xfer(input bit b, output bit r);
        wcyc(Q); m_low = ~b; wcyc(Q);
        m_scl = 1'b1; wcyc(Q);
        r = sda_line; wcyc(Q);
        m_scl = 1'b0;
    endtask

    task automatic wr_byte(input logic [7:0] d, output bit ack);
        bit r;
        for (int i = 7; i >= 0; i--) bit_xfer(d[i], r);
        bit_xfer(1'b1, r);
        ack = ~r;
    endtask

    task automatic rd_byte(input bit give_ack, output logic [7:0] d);
        bit r;
        for (int i = 7; i >= 0; i--) begin
            bit_xfer(1'b1, r);
            d[i] = r;
        end
        bit_xfer(~give_ack, r);
    endtask

    function automatic logic [7:0] abyte(input logic [2:0] low, input bit rw);
        return {4'b1101, low, rw};
    endfunction

    function automatic logic [7:0] pat(input int k, input logic [7:0] seed);
        return 8'(k * 37) ^ seed;
    endfunction

    // start + address + command + ndata bytes, no STOP; counts acks
    task automatic do_write(input logic [2:0] low, input int ndata, input logic [7:0] seed, output int acks);
        bit a;
        acks = 0;
        bus_start();
        wr_byte(abyte(low, 1'b0), a); acks += int'(a);
        wr_byte(8'hC3, a);            acks += int'(a);
        for (int k = 0; k < ndata; k++) begin
            wr_byte(pat(k, seed), a); acks += int'(a);
        end
    endtask

    task automatic do_read(input logic [2:0] low, input int n, output logic [7:0] buf_o [16], output bit addr_ack);
        bit a;
        bus_start();
        wr_byte(abyte(low, 1'b1), a);
        addr_ack = a;
        for (int k = 0; k < n; k++) rd_byte(k != n - 1, buf_o[k]);
        bus_stop();
    endtask

    function automatic logic [95:0] build_exp(input logic [7:0] seed);
        logic [95:0] v;
        for (int k = 0; k < NB; k++) v[8*k +: 8] = pat(k, seed);
        return v;
    endfunction

    task automatic t_reset();
        chk(cfg == '0, "R9 cfg after reset", cfg, '0);
        chk(sda_line == 1'b1, "R9 SDA released after reset", 96'(sda_line), 96'(1));
    endtask

    task automatic t_full_write();
        int acks;
        do_write(3'b001, NB, 8'h21, acks);
        chk(acks == NB + 2, "R3 acks on matching write", 96'(acks), 96'(NB + 2));
        wcyc(4);
        chk(cfg == '0, "R5 no update before STOP", cfg, '0);
        bus_stop();
        exp_cfg = build_exp(8'h21);
        chk(cfg == exp_cfg, "R4 commit byte order", cfg, exp_cfg);
    endtask

    task automatic t_partial();
        int acks;
        do_write(3'b001, 7, 8'h90, acks);
        bus_stop();
        chk(cfg == exp_cfg, "R5 partial write discarded", cfg, exp_cfg);
        do_write(3'b001, NB, 8'h55, acks);
        bus_start();
        bus_stop();
        chk(cfg == exp_cfg, "R1 repeated START then STOP keeps cfg (R5)", cfg, exp_cfg);
    endtask

    task automatic t_foreign();
        int acks;
        do_write(3'b010, NB, 8'h77, acks);
        chk(acks == 0, "R3 foreign address not acked", 96'(acks), 96'(0));
        bus_stop();
        chk(cfg == exp_cfg, "R3 foreign write ignored", cfg, exp_cfg);
    endtask

    task automatic t_read();
        logic [7:0] b [16];
        bit a;
        do_read(3'b001, 16, b, a);
        chk(a, "R7 read address acked", 96'(a), 96'(1));
        chk(b[0] == 8'h05, "R7 ID byte", 96'(b[0]), 96'(8'h05));
        chk(b[1] == 8'h00, "R7 reserved byte", 96'(b[1]), 96'(8'h00));
        for (int k = 0; k < NB; k++)
            chk(b[k + 2] == exp_cfg[8*k +: 8], "R7 config byte readback", 96'(b[k + 2]), 96'(exp_cfg[8*k +: 8]));
        chk(b[14] == 8'hFF && b[15] == 8'hFF, "R7 past-end bytes", 96'({b[14], b[15]}), 96'(16'hFFFF));
    endtask

    task automatic t_overflow();
        int acks;
        logic [7:0] b [16];
        bit a;
        do_write(3'b001, NB + 2, 8'h3A, acks);
        chk(acks == NB + 4, "R6 extra bytes acked", 96'(acks), 96'(NB + 4));
        bus_stop();
        exp_cfg = build_exp(8'h3A);
        chk(cfg == exp_cfg, "R6 extra bytes ignored", cfg, exp_cfg);
        do_read(3'b001, 14, b, a);
        chk(b[2] == exp_cfg[7:0], "R6 byte 0 not overwritten", 96'(b[2]), 96'(exp_cfg[7:0]));
    endtask

    task automatic t_nack();
        logic [7:0] d;
        logic [7:0] b [16];
        bit a, r;
        bus_start();
        wr_byte(abyte(3'b001, 1'b1), a);
        rd_byte(1'b1, d);
        rd_byte(1'b1, d);
        rd_byte(1'b0, d);
        chk(d == exp_cfg[7:0], "R8 byte before NACK", 96'(d), 96'(exp_cfg[7:0]));
        for (int i = 0; i < 9; i++) begin
            bit_xfer(1'b1, r);
            chk(r == 1'b1, "R8 SDA released after NACK", 96'(r), 96'(1));
        end
        bus_stop();
        do_read(3'b001, 2, b, a);
        chk(a && b[0] == 8'h05, "R8 recovery after NACK", 96'(b[0]), 96'(8'h05));
    endtask

    task automatic t_addr_map();
        bit a;
        logic [2:0] low;
        for (int i = 0; i < 10; i++) begin
            int hi = (i < 9) ? i / 3 : 2;
            int lo = (i < 9) ? i % 3 : 2;
            int idx = 3 * hi + lo;
            s_hi = (i == 9) ? 2'b11 : 2'(hi);
            s_lo = (i == 9) ? 2'b11 : 2'(lo);
            low = (idx == 8) ? 3'd6 : 3'(idx);
            wcyc(4);
            bus_start();
            wr_byte(abyte(low, 1'b0), a);
            bus_stop();
            chk(a, "R2 strap address acked", 96'({s_hi, s_lo}), 96'(low));
            bus_start();
            wr_byte(abyte(low ^ 3'b001, 1'b0), a);
            bus_stop();
            chk(!a, "R2 neighbour address rejected", 96'({s_hi, s_lo}), 96'(low ^ 3'b001));
        end
        s_hi = 2'b00;
        s_lo = 2'b01;
        wcyc(4);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        wcyc(5);
        rst = 1'b0;
        wcyc(10);
        t_reset();
        t_full_write();
        t_partial();
        t_foreign();
        t_read();
        t_overflow();
        t_nack();
        t_addr_map();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog (all requirements) act=timeout exp=completion");
            summary();
            $finish;
        end
    end
endmodule